// File: doc/BRIEF.md
# NAND-Style Read-Only Memory Target

This block is the device side of a byte-wide, NAND-style read-only memory. Strobe pins come from an external host. The block samples them on a fast system clock and takes in a command byte and three address bytes. It then serves a serial byte stream that advances on each read-strobe rising edge. Ready/busy is a single level output, where high means ready. A board-level open-drain driver would pull the line low when this output is low.

Each page holds 528 bytes: 512 main bytes and 16 spare bytes. Each block holds 32 pages. The read command selects one of three regions to start in: the first half of the main bytes, the second half of the main bytes, or the spare area. The byte stream runs on across page boundaries until it reaches the end of the block. Each time the stream crosses into a new page, the block pauses with an array-access busy interval.

The contents are computed rather than stored. Array access delay and reset delay are both parameters counted in clock cycles.

Top module: `nand_rom_target`

## Requirements
- R1: Command 00h loads column = first address byte (0..255). Command 01h loads column = 256 + first address byte (256..511).
- R2: A main byte at page p and column c < 512 reads as c[7:0] ^ {p[6:0], c[8]} ^ p[14:7]. Every byte at column 512..527 reads as FFh.
- R3: The second address byte sets page bits 7..0. Bits 6..0 of the third address byte set page bits 14..8, and bit 7 of the third byte is ignored.
- R4: After command 50h, column = 512 + bits 3..0 of the first address byte, and bits 7..4 of that byte are ignored.
- R5: After the third address byte, ready_o is low for exactly ACC_CYC clock cycles. It then goes high and reading may start.
- R6: Each read-strobe rising edge in the read state advances the column. At column 527 the page increments, the column restarts at 0 (modes 00h/01h) or 512 (mode 50h), and ready_o drops for an access interval.
- R7: After column 527 of the last page in a block (page bits 4..0 all ones), reading stops. ready_o stays high and the bus is no longer driven.
- R8: dq_oe_o is high only in the read state while chip enable is low and the read strobe is low.
- R9: While busy, any command byte other than FFh is ignored. The pending access completes with the original mode and address.
- R10: Command FFh is accepted at any time. It drops ready_o for exactly RST_CYC cycles and leaves the block with no read mode until a new command and address arrive.
- R11: Command bytes other than 00h, 01h, 50h and FFh are ignored, and an ongoing read continues unchanged.
- R12: After rst_ni, ready_o is high and dq_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cle_i | input | 1 | Command latch strobe qualifier |
| ale_i | input | 1 | Address latch strobe qualifier |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write strobe, active low; bytes latch on its rising edge |
| re_ni | input | 1 | Read strobe, active low; column advances on its rising edge |
| dq_i | input | 8 | Command/address byte from host |
| dq_o | output | 8 | Read data byte |
| dq_oe_o | output | 1 | Output enable for the data bus |
| ready_o | output | 1 | High = ready, low = busy |

## Verification
The bench targets these corner cases and the fault each one exposes:

- **Page wrap.** A start column near 527 forces the wrap into the next page. A design with the wrong wrap target in spare mode would show busy one read too early or too late.
- **Block end.** A start in page 31 checks the block-end stop. A design that keeps streaming there would drop ready or drive the bus.
- **Ignored upper bits.** A third address byte with bit 7 set, and a spare-mode column byte with its upper nibble set, check that those bits are ignored. A design that uses them would return wrong data or mistime the busy pulse.
- **Commands during busy and illegal codes.** Commands issued during busy, and an illegal code issued mid-read, must leave the data stream unchanged.
- **Reset.** A reset during an access must leave the bus undriven afterwards.
- **Busy lengths.** Busy is measured cycle-exactly against both interval parameters.

// File: rtl/nrom_pkg.sv
package nrom_pkg;
  localparam int COL_W      = 10;
  localparam int PAGE_W     = 15;
  localparam int MAIN_BYTES = 512;
  localparam int PAGE_BYTES = 528;

  localparam logic [7:0] CMD_LO    = 8'h00;
  localparam logic [7:0] CMD_HI    = 8'h01;
  localparam logic [7:0] CMD_SPARE = 8'h50;
  localparam logic [7:0] CMD_RST   = 8'hFF;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_ACC, ST_READ, ST_RST} st_e;
  typedef enum logic [1:0] {M_LO, M_HI, M_SPARE} mode_e;
endpackage

// File: rtl/nrom_sync.sv
module nrom_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/nrom_array.sv
module nrom_array
  import nrom_pkg::*;
(
  input  logic [PAGE_W-1:0] page_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [7:0]        byte_o
);
  always_comb begin
    if (col_i >= COL_W'(MAIN_BYTES)) byte_o = 8'hFF;
    else byte_o = col_i[7:0] ^ {page_i[6:0], col_i[8]} ^ page_i[14:7];
  end
endmodule

// File: rtl/nand_rom_target.sv
module nand_rom_target
  import nrom_pkg::*;
#(
  parameter int ACC_CYC   = 40,
  parameter int RST_CYC   = 60,
  parameter int BLK_PAGES = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       ce_ni,
  input  logic       we_ni,
  input  logic       re_ni,
  input  logic [7:0] dq_i,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  output logic       ready_o
);
  localparam int MAX_CYC = (ACC_CYC > RST_CYC) ? ACC_CYC : RST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BLK_W   = $clog2(BLK_PAGES);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  logic       cle_s, ale_s, ce_s, we_s, re_s;
  logic [7:0] dq_s;

  nrom_sync #(.W(13), .RST_VAL(13'b0_0_111_00000000)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cle_i, ale_i, ce_ni, we_ni, re_ni, dq_i}),
    .q_o    ({cle_s, ale_s, ce_s, we_s, re_s, dq_s})
  );

  st_e               st;
  mode_e             mode;
  logic [COL_W-1:0]  col;
  logic [PAGE_W-1:0] page;
  logic [1:0]        acnt;
  logic [CNT_W-1:0]  cnt;
  logic              we_q, re_q;
  logic [7:0]        arr_byte;

  wire we_rise  = we_s & ~we_q;
  wire re_rise  = re_s & ~re_q;
  wire cmd_stb  = we_rise & cle_s & ~ale_s & ~ce_s;
  wire addr_stb = we_rise & ale_s & ~cle_s & ~ce_s;
  wire busy     = (st == ST_ACC) || (st == ST_RST);
  wire legal_rd = (dq_s == CMD_LO) || (dq_s == CMD_HI) || (dq_s == CMD_SPARE);
  wire blk_last = &page[BLK_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st   <= ST_IDLE;
      mode <= M_LO;
      col  <= '0;
      page <= '0;
      acnt <= '0;
      cnt  <= '0;
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_s;
      re_q <= re_s;
      if (cmd_stb && dq_s == CMD_RST) begin
        st  <= ST_RST;
        cnt <= CNT_W'(RST_CYC - 1);
      end else if (cmd_stb && !busy && legal_rd) begin
        st   <= ST_ADDR;
        acnt <= '0;
        mode <= (dq_s == CMD_LO) ? M_LO : (dq_s == CMD_HI) ? M_HI : M_SPARE;
      end else begin
        unique case (st)
          ST_ADDR: if (addr_stb) begin
            acnt <= acnt + 2'd1;
            unique case (acnt)
              2'd0: unique case (mode)
                M_LO:    col <= {2'b00, dq_s};
                M_HI:    col <= {2'b01, dq_s};
                default: col <= COL_W'(MAIN_BYTES) + COL_W'(dq_s[3:0]);
              endcase
              2'd1: page[7:0] <= dq_s;
              default: begin
                page[14:8] <= dq_s[6:0]; // bit 7 ignored
                st         <= ST_ACC;
                cnt        <= CNT_W'(ACC_CYC - 1);
              end
            endcase
          end
          ST_ACC:  if (cnt == '0) st <= ST_READ; else cnt <= cnt - CNT_W'(1);
          ST_RST:  if (cnt == '0) st <= ST_IDLE; else cnt <= cnt - CNT_W'(1);
          ST_READ: if (re_rise && !ce_s) begin
            if (col == LAST_COL) begin
              if (blk_last) st <= ST_IDLE;
              else begin
                page <= page + PAGE_W'(1);
                col  <= (mode == M_SPARE) ? COL_W'(MAIN_BYTES) : '0;
                st   <= ST_ACC;
                cnt  <= CNT_W'(ACC_CYC - 1);
              end
            end else col <= col + COL_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  nrom_array u_array (.page_i(page), .col_i(col), .byte_o(arr_byte));

  assign ready_o = ~busy;
  assign dq_oe_o = (st == ST_READ) & ~ce_s & ~re_s;
  assign dq_o    = dq_oe_o ? arr_byte : 8'h00;

  p_oe_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> ready_o);
  p_col_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col <= LAST_COL);
  p_spare_col_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_READ && mode == M_SPARE) |-> col >= COL_W'(MAIN_BYTES));
  p_acc_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ACC && cnt != '0 && !cmd_stb) |=> (st == ST_ACC && cnt == $past(cnt) - CNT_W'(1)));
  p_col_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_READ && re_rise && !ce_s && col != LAST_COL && !cmd_stb) |=> col == $past(col) + COL_W'(1));
  p_busy_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ACC && cnt != '0 && cmd_stb && dq_s != CMD_RST) |=> (st == ST_ACC && mode == $past(mode)));
  p_rst_enter_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb && dq_s == CMD_RST) |=> (st == ST_RST && !ready_o));
endmodule

// File: tb/nand_rom_target_tb.sv
module nand_rom_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACC = 40;
  localparam int RST = 60;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cle = 0, ale = 0, ce_n = 1, we_n = 1, re_n = 1;
  logic [7:0] dq_in = 0, dq_out;
  logic oe, ready;
  int checks = 0, errors = 0;
  int low_run = 0, last_busy = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_rom_target #(.ACC_CYC(ACC), .RST_CYC(RST), .BLK_PAGES(32)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cle_i(cle), .ale_i(ale), .ce_ni(ce_n),
    .we_ni(we_n), .re_ni(re_n), .dq_i(dq_in), .dq_o(dq_out),
    .dq_oe_o(oe), .ready_o(ready));

  always @(negedge clk) begin
    if (rst_ni) begin
      if (!ready) low_run++;
      else if (low_run != 0) begin last_busy = low_run; low_run = 0; end
    end
  end

  function automatic logic [7:0] exp_byte(input int p, input int c);
    logic [14:0] pv = 15'(p);
    logic [9:0]  cv = 10'(c);
    if (c >= 512) return 8'hFF;
    return cv[7:0] ^ {pv[6:0], cv[8]} ^ pv[14:7];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wpulse(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); cle = c; ale = a; dq_in = d;
    repeat (2) @(negedge clk); we_n = 0;
    repeat (4) @(negedge clk); we_n = 1;
    repeat (4) @(negedge clk); cle = 0; ale = 0;
  endtask

  task automatic cmd(input logic [7:0] d); wpulse(1, 0, d); endtask

  task automatic addr3(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2);
    wpulse(0, 1, a0); wpulse(0, 1, a1); wpulse(0, 1, a2);
  endtask

  task automatic rd(output logic [7:0] d, output logic e);
    @(negedge clk); re_n = 0;
    repeat (5) @(negedge clk); d = dq_out; e = oe;
    re_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 2000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(ready, "ready timeout", ready, 1);
  endtask

  task automatic t_reset();
    chk(ready == 1, "R12 ready after reset", ready, 1);
    chk(oe == 0, "R12 bus idle after reset", oe, 0);
  endtask

  task automatic t_first_half();
    logic [7:0] d; logic e;
    cmd(8'h00); addr3(8'h0A, 8'h05, 8'h00);
    chk(ready == 0, "R5 busy after address", ready, 0);
    wait_ready();
    chk(last_busy == ACC, "R5 access busy length", last_busy, ACC);
    for (int i = 0; i < 3; i++) begin
      rd(d, e);
      chk(e == 1, "R8 oe during read strobe", e, 1);
      chk(d == exp_byte(5, 10 + i), "R1 R2 first-half data", d, exp_byte(5, 10 + i));
    end
    chk(oe == 0, "R8 oe off with strobe high", oe, 0);
    @(negedge clk); ce_n = 1; re_n = 0;
    repeat (5) @(negedge clk);
    chk(oe == 0, "R8 oe off with chip disabled", oe, 0);
    re_n = 1; repeat (5) @(negedge clk); ce_n = 0;
    rd(d, e);
    chk(d == exp_byte(5, 13), "R8 column held while disabled", d, exp_byte(5, 13));
  endtask

  task automatic t_second_half_wrap();
    logic [7:0] d; logic e; bit ok = 1;
    cmd(8'h01); addr3(8'hFA, 8'h07, 8'h81);
    wait_ready();
    for (int i = 0; i < 22; i++) begin
      rd(d, e);
      if (d != exp_byte(16'h107, 506 + i)) begin
        ok = 0;
        chk(0, "R1 R3 second-half data", d, exp_byte(16'h107, 506 + i));
      end
    end
    chk(ok, "R3 third byte bit7 ignored", ok, 1);
    chk(ready == 0, "R6 busy at page end", ready, 0);
    wait_ready();
    rd(d, e);
    chk(d == exp_byte(16'h108, 0), "R6 wrap to column 0 next page", d, exp_byte(16'h108, 0));
  endtask

  task automatic t_spare();
    logic [7:0] d; logic e;
    cmd(8'h50); addr3(8'hF3, 8'h02, 8'h00);
    wait_ready();
    for (int i = 0; i < 12; i++) begin
      rd(d, e);
      if (d != 8'hFF) chk(0, "R2 spare reads FF", d, 8'hFF);
    end
    chk(ready == 1, "R4 upper nibble ignored, no early busy", ready, 1);
    rd(d, e);
    chk(d == 8'hFF && ready == 0, "R4 R6 busy after column 527", {d, 7'b0, ready}, 16'hFF00);
    wait_ready();
    for (int i = 0; i < 15; i++) rd(d, e);
    chk(ready == 1, "R6 spare wrap restarts at 512", ready, 1);
    rd(d, e);
    chk(ready == 0, "R6 busy after 16 spare bytes", ready, 0);
    wait_ready();
  endtask

  task automatic t_block_end();
    logic [7:0] d; logic e;
    cmd(8'h01); addr3(8'hFE, 8'h1F, 8'h00);
    wait_ready();
    for (int i = 0; i < 18; i++) rd(d, e);
    repeat (4) @(negedge clk);
    chk(ready == 1, "R7 no busy at block end", ready, 1);
    rd(d, e);
    chk(e == 0, "R7 bus idle after block end", e, 0);
  endtask

  task automatic t_busy_cmd();
    logic [7:0] d; logic e;
    cmd(8'h00); addr3(8'h20, 8'h03, 8'h00);
    cmd(8'h50); cmd(8'h01);
    wait_ready();
    rd(d, e);
    chk(d == exp_byte(3, 32), "R9 command during busy ignored", d, exp_byte(3, 32));
    rd(d, e);
    chk(d == exp_byte(3, 33), "R9 stream intact", d, exp_byte(3, 33));
    cmd(8'h30);
    chk(ready == 1, "R11 illegal command no busy", ready, 1);
    rd(d, e);
    chk(d == exp_byte(3, 34) && e, "R11 illegal command ignored", d, exp_byte(3, 34));
  endtask

  task automatic t_reset_cmd();
    logic [7:0] d; logic e;
    cmd(8'h00); addr3(8'h00, 8'h04, 8'h00);
    cmd(8'hFF);
    chk(ready == 0, "R10 busy after reset command", ready, 0);
    wait_ready();
    rd(d, e);
    chk(e == 0, "R10 no read mode after reset", e, 0);
    cmd(8'hFF);
    wait_ready();
    chk(last_busy == RST, "R10 reset busy length", last_busy, RST);
    cmd(8'h00); addr3(8'h07, 8'h04, 8'h00);
    wait_ready();
    rd(d, e);
    chk(d == exp_byte(4, 7), "R10 read after new command", d, exp_byte(4, 7));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);
    ce_n = 0;
    t_reset();
    t_first_half();
    t_second_half_wrap();
    t_spare();
    t_block_end();
    t_busy_cmd();
    t_reset_cmd();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule